// File: doc/BRIEF.md
# Interrupt Status and Mask Register Bank

This block collects single-cycle event pulses from a serial bus engine and turns them into one level-sensitive interrupt request for a processor. Each event sets a sticky pending bit; software clears pending bits by writing ones to the pending register, so writing back the value it has just read acknowledges everything it saw.

Alongside the pending bits sits a per-bit mask that software cannot write directly. Software unmasks a source by writing a one to an unmask register and masks it again by writing a one to a separate mask-set register. Both of those registers are write-only. The mask itself can only be read. The interrupt line is high when at least one pending bit is unmasked, and it is registered once before it leaves the block.

Top module: `intr_regbank`

## Requirements
- R1: While and after reset, all pending bits read 0, every implemented mask bit reads 1 (mask reads 0x2FF), and `irq` is 0.
- R2: An event pulse on an implemented bit sets that pending bit at the next clock edge, and the bit stays set after the pulse ends until software clears it.
- R3: A write to the pending register at offset 0x10 clears each pending bit whose data bit is 1. Bits written with 0 are left unchanged.
- R4: When an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: A write to the unmask register at offset 0x24 clears each mask bit whose data bit is 1. Other mask bits are left unchanged.
- R6: A write to the mask-set register at offset 0x28 sets each mask bit whose data bit is 1. Other mask bits are left unchanged.
- R7: The mask register at offset 0x20 is read-only: a write there leaves both mask and pending bits unchanged.
- R8: `irq` equals the OR over all bits of (pending AND NOT mask) as it stood one clock earlier.
- R9: Reads of offsets 0x24, 0x28 and of any unmapped word return 0. Bit 8 and bits 10 to 31 of every read return 0.
- R10: The bit layout shared by all four registers is: bit 0 transfer done, bit 1 data level, bit 2 no-acknowledge, bit 3 timeout, bit 4 target ready, bit 5 receive overflow, bit 6 transmit overflow, bit 7 receive underflow, bit 9 arbitration lost. An event on bit 8 has no effect. Offsets are decoded per 32-bit word, so the low two address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 8 | Byte address of the register accessed |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| evt | input | 10 | Event pulses from the bus engine, one per source bit |
| irq | output | 1 | Combined interrupt request, registered |

## Verification
A wrong pending bit shows on `rd_data` in the first cycle in which the pending offset is addressed after the faulty edge. It also shows on `irq` one edge later whenever that bit is unmasked. A wrong mask bit is likewise visible at once through a read of offset 0x20, but reaches `irq` only if the matching pending bit is set. For that reason the bench sweeps random mask and pending patterns and rotates the read address every cycle. That way a corrupted state bit is exposed within a few cycles, not left to hide behind a masked source.

// File: rtl/intr_regbank_pkg.sv
package intr_regbank_pkg;

   // one-hot select of the four mapped words
   typedef struct packed {
      logic pend;
      logic mask;
      logic unmask;
      logic setmask;
   } rb_sel_t;

   localparam rb_sel_t RB_SEL_NONE = '{pend: 1'b0, mask: 1'b0, unmask: 1'b0, setmask: 1'b0};

endpackage

// File: rtl/intr_regbank_decode.sv
module intr_regbank_decode
   import intr_regbank_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned OFS_PEND    = 'h10,
   parameter int unsigned OFS_MASK    = 'h20,
   parameter int unsigned OFS_UNMASK  = 'h24,
   parameter int unsigned OFS_SETMASK = 'h28,
   parameter bit          WORD_DECODE = 1'b1
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   output rb_sel_t           rd_sel,
   output rb_sel_t           wr_sel
);
   localparam int unsigned LSB = WORD_DECODE ? 2 : 0;

   localparam logic [ADDR_W-1:0] A_PEND    = ADDR_W'(OFS_PEND);
   localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(OFS_MASK);
   localparam logic [ADDR_W-1:0] A_UNMASK  = ADDR_W'(OFS_UNMASK);
   localparam logic [ADDR_W-1:0] A_SETMASK = ADDR_W'(OFS_SETMASK);

   rb_sel_t hit;

   always_comb begin
      hit         = RB_SEL_NONE;
      hit.pend    = (addr[ADDR_W-1:LSB] == A_PEND[ADDR_W-1:LSB]);
      hit.mask    = (addr[ADDR_W-1:LSB] == A_MASK[ADDR_W-1:LSB]);
      hit.unmask  = (addr[ADDR_W-1:LSB] == A_UNMASK[ADDR_W-1:LSB]);
      hit.setmask = (addr[ADDR_W-1:LSB] == A_SETMASK[ADDR_W-1:LSB]);
   end

   assign rd_sel = hit;

   always_comb begin
      wr_sel = RB_SEL_NONE;
      if (wr_en) begin
         wr_sel.pend    = hit.pend;
         wr_sel.unmask  = hit.unmask;
         wr_sel.setmask = hit.setmask;
         // the mask word itself is read-only: no write select
      end
   end

endmodule

// File: rtl/intr_regbank_cell.sv
module intr_regbank_cell #(
   parameter bit MASK_RST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_in,
   input  logic clr_hit,
   input  logic unmask_hit,
   input  logic setmask_hit,
   output logic pend_o,
   output logic mask_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_o <= 1'b0;
      end else if (evt_in) begin
         pend_o <= 1'b1;
      end else if (clr_hit) begin
         pend_o <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_o <= MASK_RST;
      end else if (unmask_hit) begin
         mask_o <= 1'b0;
      end else if (setmask_hit) begin
         mask_o <= 1'b1;
      end
   end

endmodule

// File: rtl/intr_regbank_rdmux.sv
module intr_regbank_rdmux
   import intr_regbank_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned EVT_W  = 10
) (
   input  rb_sel_t           rd_sel,
   input  logic [EVT_W-1:0]  pend,
   input  logic [EVT_W-1:0]  mask,
   output logic [DATA_W-1:0] rd_data
);
   logic [EVT_W-1:0] word;

   always_comb begin
      word = '0;
      if (rd_sel.pend) begin
         word = pend;
      end else if (rd_sel.mask) begin
         word = mask;
      end
   end

   always_comb begin
      rd_data              = '0;
      rd_data[EVT_W-1:0]   = word;
   end

endmodule

// File: rtl/intr_regbank_irq.sv
module intr_regbank_irq #(
   parameter int unsigned EVT_W   = 10,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] pend,
   input  logic [EVT_W-1:0] mask,
   output logic             irq
);
   logic any_live;

   assign any_live = |(pend & ~mask);

   generate
      if (IRQ_REG) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq_q <= 1'b0;
            end else begin
               irq_q <= any_live;
            end
         end
         assign irq = irq_q;
      end else begin : g_comb
         assign irq = any_live;
      end
   endgenerate

endmodule

// File: rtl/intr_regbank.sv
module intr_regbank
   import intr_regbank_pkg::*;
#(
   parameter int unsigned          DATA_W      = 32,
   parameter int unsigned          ADDR_W      = 8,
   parameter int unsigned          EVT_W       = 10,
   parameter logic [EVT_W-1:0]     VALID_BITS  = 10'h2FF,
   parameter int unsigned          OFS_PEND    = 'h10,
   parameter int unsigned          OFS_MASK    = 'h20,
   parameter int unsigned          OFS_UNMASK  = 'h24,
   parameter int unsigned          OFS_SETMASK = 'h28,
   parameter bit                   WORD_DECODE = 1'b1,
   parameter bit                   IRQ_REG     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic [EVT_W-1:0]  evt,
   output logic              irq
);
   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   generate
      if (EVT_W > DATA_W) begin : g_chk_width
         $error("event vector wider than data word");
      end
      if (EVT_W == 0) begin : g_chk_evt
         $error("event vector must not be empty");
      end
      if (OFS_PEND >= ADDR_SPAN || OFS_MASK >= ADDR_SPAN ||
          OFS_UNMASK >= ADDR_SPAN || OFS_SETMASK >= ADDR_SPAN) begin : g_chk_span
         $error("register offset outside address space");
      end
      if (WORD_DECODE && (((OFS_PEND | OFS_MASK | OFS_UNMASK | OFS_SETMASK) & 3) != 0)) begin : g_chk_align
         $error("register offsets must be word aligned");
      end
      if ((OFS_PEND >> 2) == (OFS_MASK >> 2) || (OFS_PEND >> 2) == (OFS_UNMASK >> 2) ||
          (OFS_PEND >> 2) == (OFS_SETMASK >> 2) || (OFS_MASK >> 2) == (OFS_UNMASK >> 2) ||
          (OFS_MASK >> 2) == (OFS_SETMASK >> 2) || (OFS_UNMASK >> 2) == (OFS_SETMASK >> 2)) begin : g_chk_uniq
         $error("register offsets must be distinct words");
      end
   endgenerate

   rb_sel_t          rd_sel;
   rb_sel_t          wr_sel;
   logic [EVT_W-1:0] status_q;
   logic [EVT_W-1:0] mask_q;

   intr_regbank_decode #(
      .ADDR_W      (ADDR_W),
      .OFS_PEND    (OFS_PEND),
      .OFS_MASK    (OFS_MASK),
      .OFS_UNMASK  (OFS_UNMASK),
      .OFS_SETMASK (OFS_SETMASK),
      .WORD_DECODE (WORD_DECODE)
   ) i_decode (
      .wr_en  (wr_en),
      .addr   (addr),
      .rd_sel (rd_sel),
      .wr_sel (wr_sel)
   );

   generate
      for (genvar b = 0; b < EVT_W; b++) begin : g_bit
         if (VALID_BITS[b]) begin : g_live
            intr_regbank_cell #(
               .MASK_RST (1'b1)
            ) i_cell (
               .clk         (clk),
               .rst_n       (rst_n),
               .evt_in      (evt[b]),
               .clr_hit     (wr_sel.pend    & wr_data[b]),
               .unmask_hit  (wr_sel.unmask  & wr_data[b]),
               .setmask_hit (wr_sel.setmask & wr_data[b]),
               .pend_o      (status_q[b]),
               .mask_o      (mask_q[b])
            );
         end else begin : g_hole
            assign status_q[b] = 1'b0;
            assign mask_q[b]   = 1'b0;
         end
      end
   endgenerate

   intr_regbank_rdmux #(
      .DATA_W (DATA_W),
      .EVT_W  (EVT_W)
   ) i_rdmux (
      .rd_sel  (rd_sel),
      .pend    (status_q),
      .mask    (mask_q),
      .rd_data (rd_data)
   );

   intr_regbank_irq #(
      .EVT_W   (EVT_W),
      .IRQ_REG (IRQ_REG)
   ) i_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .pend  (status_q),
      .mask  (mask_q),
      .irq   (irq)
   );

endmodule

// File: rtl/intr_regbank_chk.sv
module intr_regbank_chk #(
   parameter int unsigned      DATA_W      = 32,
   parameter int unsigned      ADDR_W      = 8,
   parameter int unsigned      EVT_W       = 10,
   parameter logic [EVT_W-1:0] VALID_BITS  = 10'h2FF,
   parameter int unsigned      OFS_PEND    = 'h10,
   parameter int unsigned      OFS_UNMASK  = 'h24,
   parameter int unsigned      OFS_SETMASK = 'h28
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic [EVT_W-1:0]  evt,
   input logic              irq,
   input logic [EVT_W-1:0]  status_q,
   input logic [EVT_W-1:0]  mask_q
);
   localparam logic [ADDR_W-1:0] W_PEND    = ADDR_W'(OFS_PEND);
   localparam logic [ADDR_W-1:0] W_UNMASK  = ADDR_W'(OFS_UNMASK);
   localparam logic [ADDR_W-1:0] W_SETMASK = ADDR_W'(OFS_SETMASK);
   localparam logic [DATA_W-1:0] RD_LEGAL  = DATA_W'(VALID_BITS);

   logic              w_pend;
   logic              w_un;
   logic              w_set;
   logic [EVT_W-1:0]  wd;
   logic [EVT_W-1:0]  ev;

   assign w_pend = wr_en && (addr[ADDR_W-1:2] == W_PEND[ADDR_W-1:2]);
   assign w_un   = wr_en && (addr[ADDR_W-1:2] == W_UNMASK[ADDR_W-1:2]);
   assign w_set  = wr_en && (addr[ADDR_W-1:2] == W_SETMASK[ADDR_W-1:2]);
   assign wd     = wr_data[EVT_W-1:0] & VALID_BITS;
   assign ev     = evt & VALID_BITS;

   AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !w_pend |=> ((status_q & $past(status_q)) == $past(status_q))) // R2
      else $error("pending bit dropped without clear");

   AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (ev != '0) |=> ((status_q & $past(ev)) == $past(ev))) // R4
      else $error("event did not set pending bit");

   AST_CLEAR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      w_pend |=> ((status_q & $past(wd & ~ev)) == '0)) // R3
      else $error("written one did not clear pending bit");

   AST_UNMASK: assert property (@(posedge clk) disable iff (!rst_n)
      w_un |=> ((mask_q & $past(wd)) == '0)) // R5
      else $error("unmask write failed");

   AST_SETMASK: assert property (@(posedge clk) disable iff (!rst_n)
      w_set |=> ((mask_q & $past(wd)) == $past(wd))) // R6
      else $error("mask-set write failed");

   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(w_un || w_set) |=> $stable(mask_q)) // R7
      else $error("mask changed without a mask write");

   AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq == (|($past(status_q) & ~$past(mask_q))))) // R8
      else $error("irq does not follow pending and mask");

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_data & ~RD_LEGAL) == '0)) // R9
      else $error("reserved read bit set");

endmodule

bind intr_regbank intr_regbank_chk #(
   .DATA_W      (DATA_W),
   .ADDR_W      (ADDR_W),
   .EVT_W       (EVT_W),
   .VALID_BITS  (VALID_BITS),
   .OFS_PEND    (OFS_PEND),
   .OFS_UNMASK  (OFS_UNMASK),
   .OFS_SETMASK (OFS_SETMASK)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .addr     (addr),
   .wr_data  (wr_data),
   .rd_data  (rd_data),
   .evt      (evt),
   .irq      (irq),
   .status_q (status_q),
   .mask_q   (mask_q)
);

// File: tb/test_intr_regbank.sv
module test_intr_regbank;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 200000;
   localparam logic [31:0] VALID = 32'h2FF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [9:0]  evt = '0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] m_pend = '0;
   logic [31:0] m_mask = VALID;
   logic        m_irq  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   intr_regbank i_intr_regbank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (addr),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .evt     (evt),
      .irq     (irq)
   );

   function automatic logic [31:0] model_read(input logic [7:0] a);
      case (a[7:2])
         6'h04:   return m_pend;
         6'h08:   return m_mask;
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_for(input logic [7:0] a);
      case (a[7:2])
         6'h04:   return "R2";
         6'h08:   return "R5";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // one clock: inputs are set now (after a falling edge); model advances with
   // the design and both are compared at the following falling edge
   task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d,
                       input logic [9:0] e);
      logic [31:0] n_pend;
      logic [31:0] n_mask;
      logic        n_irq;
      wr_en   = we;
      addr    = a;
      wr_data = d;
      evt     = e;
      n_irq  = |(m_pend & ~m_mask);
      n_pend = m_pend;
      if (we && a[7:2] == 6'h04) n_pend = n_pend & ~d;
      n_pend = (n_pend | {22'h0, e}) & VALID;
      n_mask = m_mask;
      if (we && a[7:2] == 6'h09) n_mask = n_mask & ~d;
      if (we && a[7:2] == 6'h0A) n_mask = n_mask | d;
      n_mask = n_mask & VALID;
      @(posedge clk);
      @(negedge clk);
      m_pend = n_pend;
      m_mask = n_mask;
      m_irq  = n_irq;
      wr_en  = 1'b0;
      evt    = '0;
      check(tag_for(a), rd_data, model_read(a));
      check("R8", {31'h0, irq}, {31'h0, m_irq});
   endtask

   task automatic idle_read(input logic [7:0] a);
      step(1'b0, a, 32'h0, 10'h0);
   endtask

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] lfsr;
      logic [7:0]  addr_set [6];
      addr_set[0] = 8'h10; addr_set[1] = 8'h20; addr_set[2] = 8'h24;
      addr_set[3] = 8'h28; addr_set[4] = 8'h30; addr_set[5] = 8'h13;

      // R1: reset values
      repeat (3) @(negedge clk);
      addr = 8'h10;
      #1 check("R1", rd_data, 32'h0);
      addr = 8'h20;
      #1 check("R1", rd_data, 32'h2FF);
      check("R1", {31'h0, irq}, 32'h0);
      rst_n = 1'b1;

      // R2: event latches and stays; masked so no irq
      step(1'b0, 8'h10, 32'h0, 10'h001);
      check("R2", rd_data, 32'h001);
      idle_read(8'h10);
      check("R2", rd_data, 32'h001);
      check("R8", {31'h0, irq}, 32'h0);

      // R5: unmask bit 0, irq follows one edge later
      step(1'b1, 8'h24, 32'h1, 10'h0);
      check("R9", rd_data, 32'h0);
      check("R8", {31'h0, irq}, 32'h0);
      idle_read(8'h20);
      check("R5", rd_data, 32'h2FE);
      check("R8", {31'h0, irq}, 32'h1);

      // R3: clear bit 0, written zeros leave others
      step(1'b0, 8'h10, 32'h0, 10'h004);
      step(1'b1, 8'h10, 32'h1, 10'h0);
      check("R3", rd_data, 32'h004);
      idle_read(8'h10);
      check("R8", {31'h0, irq}, 32'h0);

      // R10: bit 8 event ignored, bit 9 latches
      step(1'b0, 8'h10, 32'h0, 10'h300);
      check("R10", rd_data, 32'h204);

      // R4: event wins over simultaneous clear
      step(1'b1, 8'h10, 32'h200, 10'h200);
      check("R4", rd_data, 32'h204);

      // R7: write to mask word changes nothing
      step(1'b1, 8'h20, 32'h0, 10'h0);
      check("R7", rd_data, 32'h2FE);
      idle_read(8'h10);
      check("R7", rd_data, 32'h204);

      // R6: mask-set restores bit 0
      step(1'b1, 8'h28, 32'h1, 10'h0);
      idle_read(8'h20);
      check("R6", rd_data, 32'h2FF);

      // R9: write-only and unmapped words read zero; reserved bits zero
      step(1'b1, 8'h24, 32'hFFFF_FFFF, 10'h0);
      idle_read(8'h28);
      check("R9", rd_data, 32'h0);
      idle_read(8'h3C);
      check("R9", rd_data, 32'h0);
      idle_read(8'h20);
      check("R9", rd_data, 32'h0);
      step(1'b0, 8'h10, 32'h0, 10'h3FF);
      check("R9", rd_data, 32'h2FF);

      // R10: byte lane bits ignored, full clear by writing back the value read
      step(1'b1, 8'h12, 32'hFFFF_FFFF, 10'h0);
      check("R10", rd_data, 32'h0);

      // mixed traffic against the model
      lfsr = 32'hACE1_2345;
      for (int i = 0; i < 2000; i++) begin
         logic we;
         logic [7:0] a;
         logic [31:0] d;
         logic [9:0] e;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         we = lfsr[3] & lfsr[7];
         a  = addr_set[lfsr[10:8] % 6];
         d  = {lfsr[15:0], lfsr[31:16]};
         e  = lfsr[20:11] & lfsr[29:20] & {10{lfsr[5]}};
         step(we, a, d, e);
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule